// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Grouped Sub-Sources

This block collects up to 32 interrupt sources and presents one request line to a processor. Each source that goes high is latched in a source-pending register. Sources enabled in a mask register take part in an arbitration that picks the lowest-numbered one. The winner is copied, one-hot, into an in-service register, and its number is held in an offset register. The processor reads these through a small synchronous register port. It acknowledges a source by writing ones to the source-pending register and then to the in-service register.

Four parent positions are not fed from the direct source inputs. Each one is driven instead by a group of eleven peripheral sub-lines: three per serial port (receive, transmit, error) and two for a touch/ADC unit. The sub-lines latch in their own write-1-to-clear sub-pending register, which has its own sub-mask. A parent is requested while any sub-bit in its group is both pending and enabled. Software must therefore clear the sub-bit before it acknowledges the parent, or the parent latches again.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, source-pending, in-service, offset and sub-pending read 0, the mask reads all ones (0xFFFFFFFF), the sub-mask reads 0x7FF, and `irq` is low.
- R2: A source input that is high for one clock sets its source-pending bit, and the bit stays set after the input drops. This happens whether or not the source is masked. Positions 6 and 24 are reserved and never become pending.
- R3: A write to source-pending clears exactly the bits written as 1. Bits written as 0 are unchanged, and a source input that is high in the same cycle as the clear keeps its bit set.
- R4: A mask bit of 1 keeps that pending source out of arbitration. A mask bit of 0 admits it.
- R5: When the in-service register is zero, the pending unmasked source with the lowest index wins at the next clock. Its bit alone is set in the in-service register, and its index is placed in the offset register.
- R6: `irq` is high exactly while the in-service register is nonzero. The in-service value holds until software clears it by writing ones to the in-service register. No new winner is chosen before that.
- R7: Sub-pending bits are laid out as follows: bits 0/1/2 are serial port 0 receive/transmit/error, bits 3/4/5 are port 1, bits 6/7/8 are port 2, bit 9 is touch and bit 10 is ADC done. A sub-line that is high for one clock latches its bit, and writing 1 to a bit clears it.
- R8: A group is live when some sub-pending bit of that group has its sub-mask bit at 0. A live group sets its parent source-pending bit. The parents are port 0 at position 25, port 1 at 26, port 2 at 27 and touch/ADC at 30. The direct source inputs at these positions are ignored.
- R9: If a parent is cleared from source-pending and in-service while its sub-pending bit is still enabled, it becomes pending and wins again. Only a clear of the sub-pending bit lets the acknowledgment take effect.
- R10: Register addresses are 0 source-pending, 1 mask, 2 in-service, 3 offset, 4 sub-pending and 5 sub-mask. `rd_data` shows the register at `addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Direct source request lines |
| sub_in | input | 11 | Peripheral sub-source request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 32 | Write data (ones clear for pending registers) |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Request line to the processor |

## Verification
Arbitration is tried with a single pending source, with two sources pending at once under different masks, and with a new source arriving while another is in service. Together these separate lowest-index selection, mask gating and the hold-until-cleared rule. Sub-source traffic is sent on one port's transmit line, on the last port's error line and on the ADC line, with some of them masked. This shows whether each sub-bit reaches the right parent, and only while it is enabled. One run acknowledges a parent while its sub-bit is still pending and another clears the sub-bit first, which exposes whether the two-step clear is honoured. A clear issued while the source is still high, and writes of all-zero data, show that set-over-clear priority and write-1-to-clear semantics hold.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [2:0] {
      RA_SRCPND = 3'd0,
      RA_MASK   = 3'd1,
      RA_INSVC  = 3'd2,
      RA_OFFSET = 3'd3,
      RA_SUBPND = 3'd4,
      RA_SUBMSK = 3'd5
   } reg_addr_e;

   localparam int unsigned SUB_W   = 11;
   localparam int unsigned NUM_GRP = 4;

   // first sub bit of a group: 0, 3, 6, 9
   function automatic int unsigned grp_lo(int unsigned g);
      return g * 3;
   endfunction

   // three lines per serial port, two for touch/ADC
   function automatic int unsigned grp_cnt(int unsigned g);
      return (g == NUM_GRP - 1) ? 2 : 3;
   endfunction
endpackage

// File: rtl/irqc_subfold.sv
module irqc_subfold
   import irqc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SUB_W-1:0]   sub_in,
   input  logic               clr_we,
   input  logic               msk_we,
   input  logic [SUB_W-1:0]   wdata,
   output logic [SUB_W-1:0]   subpend,
   output logic [SUB_W-1:0]   submask,
   output logic [NUM_GRP-1:0] grp_req
);
   logic [SUB_W-1:0] live;
   logic [SUB_W-1:0] clr_vec;

   assign clr_vec = clr_we ? wdata : '0;
   assign live    = subpend & ~submask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         subpend <= '0;
         submask <= '1;
      end else begin
         subpend <= (subpend & ~clr_vec) | sub_in;
         if (msk_we) submask <= wdata;
      end
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int unsigned LO  = grp_lo(g);
      localparam int unsigned CNT = grp_cnt(g);
      assign grp_req[g] = |live[LO +: CNT];
   end
endmodule

// File: rtl/irqc_srcpend.sv
module irqc_srcpend
   import irqc_pkg::*;
#(
   parameter int unsigned       NSRC = 32,
   parameter logic [NSRC-1:0]   RSV  = '0,
   parameter int unsigned       PARENT_POS [NUM_GRP] = '{25, 26, 27, 30}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSRC-1:0]    src_in,
   input  logic [NUM_GRP-1:0] grp_req,
   input  logic               clr_we,
   input  logic               msk_we,
   input  logic [NSRC-1:0]    wdata,
   output logic [NSRC-1:0]    srcpend,
   output logic [NSRC-1:0]    mask
);
   function automatic logic [NSRC-1:0] parent_mask();
      logic [NSRC-1:0] m = '0;
      for (int g = 0; g < NUM_GRP; g++) m[PARENT_POS[g]] = 1'b1;
      return m;
   endfunction

   localparam logic [NSRC-1:0] DIRECT = ~(RSV | parent_mask());

   logic [NSRC-1:0] par_vec;
   logic [NSRC-1:0] set_vec;
   logic [NSRC-1:0] clr_vec;

   always_comb begin
      par_vec = '0;
      for (int g = 0; g < NUM_GRP; g++) par_vec[PARENT_POS[g]] = grp_req[g];
   end

   assign set_vec = (src_in & DIRECT) | par_vec;
   assign clr_vec = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srcpend <= '0;
         mask    <= '1;
      end else begin
         srcpend <= (srcpend & ~clr_vec) | set_vec;
         if (msk_we) mask <= wdata;
      end
   end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
   parameter int unsigned NSRC  = 32,
   localparam int unsigned OFF_W = $clog2(NSRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  srcpend,
   input  logic [NSRC-1:0]  mask,
   input  logic             clr_we,
   input  logic [NSRC-1:0]  wdata,
   output logic [NSRC-1:0]  insvc,
   output logic [OFF_W-1:0] offset
);
   logic [NSRC-1:0]  cand;
   logic [OFF_W-1:0] win;
   logic             found;

   assign cand = srcpend & ~mask;

   always_comb begin
      win   = '0;
      found = 1'b0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (cand[i]) begin
            win   = OFF_W'(i);
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insvc  <= '0;
         offset <= '0;
      end else if (insvc == '0) begin
         if (found) begin
            insvc  <= NSRC'(1) << win;
            offset <= win;
         end
      end else if (clr_we) begin
         insvc <= insvc & ~wdata;
      end
   end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned     NSRC   = 32,
   parameter int unsigned     DATA_W = 32,
   parameter logic [NSRC-1:0] RSV    = NSRC'((64'd1 << 6) | (64'd1 << 24)),
   parameter int unsigned     PARENT_POS [NUM_GRP] = '{25, 26, 27, 30},
   parameter bit              RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_in,
   input  logic [SUB_W-1:0]  sub_in,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int unsigned OFF_W = $clog2(NSRC);

   if (NSRC < 2 || NSRC > DATA_W) begin : g_bad_nsrc
      $error("NSRC must lie in 2..DATA_W");
   end
   if (DATA_W < SUB_W) begin : g_bad_dw
      $error("DATA_W too narrow for sub-source register");
   end
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk_par
      if (PARENT_POS[g] >= NSRC || RSV[PARENT_POS[g]]) begin : g_bad_par
         $error("parent position out of range or reserved");
      end
   end

   logic [NSRC-1:0]    srcpend, mask, insvc;
   logic [OFF_W-1:0]   offset;
   logic [SUB_W-1:0]   subpend, submask;
   logic [NUM_GRP-1:0] grp_req;
   logic [DATA_W-1:0]  rd_nxt;
   reg_addr_e          ra;

   assign ra = reg_addr_e'(addr);

   irqc_subfold i_sub (
      .clk     (clk),
      .rst_n   (rst_n),
      .sub_in  (sub_in),
      .clr_we  (wr_en && ra == RA_SUBPND),
      .msk_we  (wr_en && ra == RA_SUBMSK),
      .wdata   (wr_data[SUB_W-1:0]),
      .subpend (subpend),
      .submask (submask),
      .grp_req (grp_req)
   );

   irqc_srcpend #(.NSRC(NSRC), .RSV(RSV), .PARENT_POS(PARENT_POS)) i_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_in  (src_in),
      .grp_req (grp_req),
      .clr_we  (wr_en && ra == RA_SRCPND),
      .msk_we  (wr_en && ra == RA_MASK),
      .wdata   (wr_data[NSRC-1:0]),
      .srcpend (srcpend),
      .mask    (mask)
   );

   irqc_arb #(.NSRC(NSRC)) i_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .srcpend (srcpend),
      .mask    (mask),
      .clr_we  (wr_en && ra == RA_INSVC),
      .wdata   (wr_data[NSRC-1:0]),
      .insvc   (insvc),
      .offset  (offset)
   );

   assign irq = |insvc;

   always_comb begin
      rd_nxt = '0;
      case (ra)
         RA_SRCPND: rd_nxt[NSRC-1:0]  = srcpend;
         RA_MASK:   rd_nxt[NSRC-1:0]  = mask;
         RA_INSVC:  rd_nxt[NSRC-1:0]  = insvc;
         RA_OFFSET: rd_nxt[OFF_W-1:0] = offset;
         RA_SUBPND: rd_nxt[SUB_W-1:0] = subpend;
         RA_SUBMSK: rd_nxt[SUB_W-1:0] = submask;
         default:   rd_nxt = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_nxt;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_nxt;
   end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
   import irqc_pkg::*;
#(
   parameter int unsigned     NSRC = 32,
   parameter logic [NSRC-1:0] RSV  = '0,
   parameter int unsigned     PARENT_POS [NUM_GRP] = '{25, 26, 27, 30},
   localparam int unsigned    OFF_W = $clog2(NSRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq,
   input logic               wr_en,
   input logic [2:0]         addr,
   input logic [NSRC-1:0]    srcpend,
   input logic [NSRC-1:0]    mask,
   input logic [NSRC-1:0]    insvc,
   input logic [OFF_W-1:0]   offset,
   input logic [NUM_GRP-1:0] grp_req
);
   a_r2_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (srcpend & RSV) == '0);

   a_r5_onehot_svc: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(insvc));

   a_r5_offset_match: assert property (@(posedge clk) disable iff (!rst_n)
      (insvc != '0) |-> insvc[offset]);

   a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (($past(srcpend) & ~$past(mask)) & (insvc - NSRC'(1))) == '0);

   a_r4_masked_out: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (insvc & $past(mask)) == '0);

   a_r6_svc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (insvc != '0 && !(wr_en && addr == RA_INSVC)) |=> $stable(insvc));

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_fold
      a_r8_parent_set: assert property (@(posedge clk) disable iff (!rst_n)
         grp_req[g] |=> srcpend[PARENT_POS[g]]);
   end
endmodule

bind irq_cascade_ctrl irqc_chk #(.NSRC(NSRC), .RSV(RSV), .PARENT_POS(PARENT_POS)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq),
   .wr_en   (wr_en),
   .addr    (addr),
   .srcpend (srcpend),
   .mask    (mask),
   .insvc   (insvc),
   .offset  (offset),
   .grp_req (grp_req)
);

// File: tb/test_irq_cascade_ctrl.sv
module test_irq_cascade_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic [10:0] sub_in = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t scb[$];
   logic  chk_req = 1'b0;
   logic  req_d = 1'b0;

   always #4 clk = ~clk;

   irq_cascade_ctrl i_irq_cascade_ctrl (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .sub_in(sub_in),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq)
   );

   // monitor: compare registered read data against queued expectations
   always @(posedge clk) req_d <= chk_req;
   always @(negedge clk) begin
      if (req_d && scb.size() > 0) begin
         item_t it;
         it = scb.pop_front();
         checks++;
         if (rd_data !== it.exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", it.tag, rd_data, it.exp);
         end
      end
   end

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      addr = a;
      it.exp = exp;
      it.tag = tag;
      scb.push_back(it);
      chk_req = 1'b1;
      @(negedge clk);
      chk_req = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      checks++;
      if (irq !== exp) begin
         errors++;
         $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
      end
   endtask

   task automatic pulse_src(input logic [31:0] v);
      @(negedge clk); src_in = v;
      @(negedge clk); src_in = '0;
   endtask

   task automatic pulse_sub(input logic [10:0] v);
      @(negedge clk); sub_in = v;
      @(negedge clk); sub_in = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 / R10 reset values and address map
      rd(3'd0, 32'h0, "R1 srcpend reset");
      rd(3'd1, 32'hFFFF_FFFF, "R1 mask reset");
      rd(3'd2, 32'h0, "R1 insvc reset");
      rd(3'd3, 32'h0, "R1 offset reset");
      rd(3'd4, 32'h0, "R1 subpend reset");
      rd(3'd5, 32'h7FF, "R10 submask reset");
      chk_irq(1'b0, "R1 irq reset");

      // R2 sticky latch while masked, R4 masked source ignored
      pulse_src(32'h8);
      idle(1);
      rd(3'd0, 32'h8, "R2 sticky pending");
      rd(3'd2, 32'h0, "R4 masked not in service");
      chk_irq(1'b0, "R4 irq stays low when masked");

      // R2 reserved positions, R8 direct parent input ignored
      pulse_src(32'h0100_0040 | 32'h0200_0000);
      idle(1);
      rd(3'd0, 32'h8, "R2 reserved/R8 parent input ignored");

      // R5 lowest index wins
      pulse_src(32'h2);
      wr(3'd1, 32'hFFFF_FFF5);
      idle(2);
      rd(3'd2, 32'h2, "R5 lowest wins insvc");
      rd(3'd3, 32'd1, "R5 offset of winner");
      chk_irq(1'b1, "R6 irq high while in service");

      // R6 hold while a lower source arrives
      pulse_src(32'h1);
      wr(3'd1, 32'hFFFF_FFF4);
      idle(2);
      rd(3'd2, 32'h2, "R6 holds until cleared");

      // R3 / R6 clear then re-arbitrate
      wr(3'd0, 32'h2);
      wr(3'd2, 32'h2);
      idle(2);
      rd(3'd2, 32'h1, "R6 new winner after clear");
      rd(3'd3, 32'd0, "R5 offset zero");
      rd(3'd0, 32'h9, "R3 only written bit cleared");
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h0);
      idle(1);
      rd(3'd0, 32'h9, "R3 zero write no effect srcpend");
      rd(3'd2, 32'h1, "R3 zero write no effect insvc");
      wr(3'd0, 32'h9);
      wr(3'd2, 32'h1);
      chk_irq(1'b0, "R6 irq low after clear");
      idle(2);
      rd(3'd2, 32'h0, "R6 no winner left");

      // R3 set wins over simultaneous clear
      @(negedge clk); src_in = 32'h4;
      wr(3'd0, 32'h4);
      @(negedge clk); src_in = '0;
      rd(3'd0, 32'h4, "R3 set beats clear");
      wr(3'd0, 32'h4);
      rd(3'd0, 32'h0, "R3 clear after input drops");

      // R7 / R8 sub-source port 1 transmit
      pulse_sub(11'h010);
      idle(1);
      rd(3'd4, 32'h10, "R7 sub bit latched");
      rd(3'd0, 32'h0, "R8 masked sub does not fold");
      wr(3'd5, 32'h7EF);
      idle(2);
      rd(3'd0, 32'h0400_0000, "R8 port1 folds to 26");
      wr(3'd1, ~32'h0400_0000);
      idle(2);
      rd(3'd2, 32'h0400_0000, "R8 parent in service");
      rd(3'd3, 32'd26, "R8 parent offset");

      // R9 parent reasserts while sub still pending
      wr(3'd0, 32'h0400_0000);
      wr(3'd2, 32'h0400_0000);
      idle(2);
      rd(3'd0, 32'h0400_0000, "R9 parent re-pends");
      rd(3'd2, 32'h0400_0000, "R9 parent wins again");
      wr(3'd4, 32'h10);
      wr(3'd0, 32'h0400_0000);
      wr(3'd2, 32'h0400_0000);
      idle(2);
      rd(3'd0, 32'h0, "R9 cleared after sub clear");
      rd(3'd4, 32'h0, "R7 sub write-1-clear");
      chk_irq(1'b0, "R9 irq low after full ack");

      // R7 / R8 ADC and port2 error groups; port0 receive masked
      wr(3'd5, 32'h3FF);
      pulse_sub(11'h401);
      idle(2);
      rd(3'd0, 32'h4000_0000, "R8 ADC folds to 30, port0 masked");
      wr(3'd5, 32'h2FF);
      pulse_sub(11'h100);
      idle(2);
      rd(3'd4, 32'h501, "R7 sub layout bits 0,8,10");
      rd(3'd0, 32'h4800_0000, "R8 port2 err folds to 27");
      wr(3'd1, 32'h0);
      idle(2);
      rd(3'd2, 32'h0800_0000, "R5 lowest among parents");
      rd(3'd3, 32'd27, "R5 offset 27");

      idle(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule